// File: doc/BRIEF.md
# Dual-Port Memory Pin Router with Chip-Select Steering

This block sits between two serial memory controllers and two physical memory ports. Each controller presents a clock, an inverted clock, a 16-bit data bus with per-bit output enables, two data strobes with enables, one active-low chip-select and a chip-select selector bit. Port 1 carries a 16-bit bus and two strobes. Port 2 carries an 8-bit bus and one strobe. Both ports have two chip-select pins. A registered configuration picks one of four whole-interface mappings: straight, crossed, or both controllers sharing port 1 or sharing port 2. In the shared mappings an external arbiter supplies the index of the controller that owns the bus.

The data path is purely combinational. Only the configuration is registered. A configuration write is taken only while both controller enables are low. A controller's single chip-select is steered to port chip-select pin 1 or 2 by its selector, and software override bits can replace both selectors. The pins are level signals with no handshake, so there is no back-pressure. Every output follows its inputs in the same cycle, and the bench checks them on every clock.

Top module: `spr_pin_router`

## Requirements
- R1: After reset the configuration is share=0, alt=0, override off, so controller A drives port 1 and controller B drives port 2.
- R2: With share=0 and alt=0, port 1 carries A's clock, inverted clock, data, enables and strobes, and port 2 carries B's.
- R3: With share=0 and alt=1, port 1 carries B's signals and port 2 carries A's.
- R4: With share=1 and alt=0, port 1 carries the owner's signals (owner=0 selects A, owner=1 selects B). Port 2 is idle: clocks 0, data 0, all output enables 0, both chip-selects 1.
- R5: With share=1 and alt=1, port 2 carries the owner's signals and port 1 is idle in the same way.
- R6: A routed controller's chip-select appears on port chip-select pin 1 (bit 0) when its effective selector is 0 and on pin 2 (bit 1) when it is 1. The other pin is held at 1.
- R7: With the override enable set, the override bits (ovr_sel_a for A, ovr_sel_b for B) replace the selectors coming from the controllers.
- R8: A configuration write (cfg_we) is ignored while either controller enable is high.
- R9: A controller reads data and strobe inputs only from the port currently mapped or granted to it. A controller with no port reads zeros.
- R10: On port 2 only data bits 7:0 and strobe 0 are routed. The controller's upper data byte and second strobe read as zero.
- R11: In shared modes the non-owner's chip-select has no effect on any port pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_share | input | 1 | 1: both controllers share one port |
| cfg_alt | input | 1 | Crossed mapping, or shared target is port 2 |
| cfg_ovr_en | input | 1 | Selector override enable |
| cfg_ovr_sel_a | input | 1 | Override selector for controller A |
| cfg_ovr_sel_b | input | 1 | Override selector for controller B |
| owner | input | 1 | Bus owner in shared modes (0=A, 1=B) |
| a_en | input | 1 | Controller A enabled |
| a_sck | input | 1 | Controller A clock |
| a_sck_n | input | 1 | Controller A inverted clock |
| a_dout | input | DW | Controller A output data |
| a_doe | input | DW | Controller A data output enables |
| a_din | output | DW | Data returned to controller A |
| a_dqs_o | input | SW | Controller A strobe outputs |
| a_dqs_oe | input | SW | Controller A strobe enables |
| a_dqs_i | output | SW | Strobes returned to controller A |
| a_cs_n | input | 1 | Controller A chip-select, active low |
| a_cs_sel | input | 1 | Controller A chip-select selector |
| b_en | input | 1 | Controller B enabled |
| b_sck | input | 1 | Controller B clock |
| b_sck_n | input | 1 | Controller B inverted clock |
| b_dout | input | DW | Controller B output data |
| b_doe | input | DW | Controller B data output enables |
| b_din | output | DW | Data returned to controller B |
| b_dqs_o | input | SW | Controller B strobe outputs |
| b_dqs_oe | input | SW | Controller B strobe enables |
| b_dqs_i | output | SW | Strobes returned to controller B |
| b_cs_n | input | 1 | Controller B chip-select, active low |
| b_cs_sel | input | 1 | Controller B chip-select selector |
| p1_sck | output | 1 | Port 1 clock |
| p1_sck_n | output | 1 | Port 1 inverted clock |
| p1_dout | output | DW | Port 1 output data |
| p1_doe | output | DW | Port 1 data output enables |
| p1_din | input | DW | Port 1 input data |
| p1_dqs_o | output | SW | Port 1 strobe outputs |
| p1_dqs_oe | output | SW | Port 1 strobe enables |
| p1_dqs_i | input | SW | Port 1 strobe inputs |
| p1_cs_n | output | 2 | Port 1 chip-select pins |
| p2_sck | output | 1 | Port 2 clock |
| p2_sck_n | output | 1 | Port 2 inverted clock |
| p2_dout | output | NW | Port 2 output data |
| p2_doe | output | NW | Port 2 data output enables |
| p2_din | input | NW | Port 2 input data |
| p2_dqs_o | output | NS | Port 2 strobe output |
| p2_dqs_oe | output | NS | Port 2 strobe enable |
| p2_dqs_i | input | NS | Port 2 strobe input |
| p2_cs_n | output | 2 | Port 2 chip-select pins |

## Verification
The hardest case to reach from the ports is a configuration write arriving while a controller is enabled. It must leave the routing untouched even though the write strobe and new mode bits are present. The stimulus raises an enable and then drives writes with deliberately different mode values for many cycles. Those cycles also carry random data and selectors, so any leak of the new mode shows up as a routing mismatch. Shared-mode cycles flip the owner and both selectors at random, so the non-owner's chip-select toggles while the owner's steering is compared pin by pin.

// File: rtl/spr_pkg.sv
package spr_pkg;
  typedef enum logic [1:0] {
    SRC_A    = 2'd0,
    SRC_B    = 2'd1,
    SRC_NONE = 2'd2
  } src_e;

  // Which controller feeds a given port (port_is_2 = 0 for port 1).
  function automatic src_e route_src(input logic share, input logic alt,
                                     input logic own, input logic port_is_2);
    src_e s;
    if (!share) begin
      s = ((port_is_2 ^ alt) == 1'b0) ? SRC_A : SRC_B;
    end else if (alt == port_is_2) begin
      s = own ? SRC_B : SRC_A;
    end else begin
      s = SRC_NONE;
    end
    return s;
  endfunction
endpackage

// File: rtl/spr_cfg.sv
module spr_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic busy,
  input  logic share_d,
  input  logic alt_d,
  input  logic ovr_en_d,
  input  logic ovr_a_d,
  input  logic ovr_b_d,
  output logic share_q,
  output logic alt_q,
  output logic ovr_en_q,
  output logic ovr_a_q,
  output logic ovr_b_q
);
  logic take;
  assign take = we & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      share_q  <= 1'b0;
      alt_q    <= 1'b0;
      ovr_en_q <= 1'b0;
      ovr_a_q  <= 1'b0;
      ovr_b_q  <= 1'b0;
    end else if (take) begin
      share_q  <= share_d;
      alt_q    <= alt_d;
      ovr_en_q <= ovr_en_d;
      ovr_a_q  <= ovr_a_d;
      ovr_b_q  <= ovr_b_d;
    end
  end
endmodule

// File: rtl/spr_port_mux.sv
module spr_port_mux #(
  parameter int CW = 16,
  parameter int CS = 2,
  parameter int PW = 16,
  parameter int PS = 2
) (
  input  spr_pkg::src_e          src,
  input  logic [1:0]             sck,
  input  logic [1:0]             sck_n,
  input  logic [1:0][CW-1:0]     dout,
  input  logic [1:0][CW-1:0]     doe,
  input  logic [1:0][CS-1:0]     dqs_o,
  input  logic [1:0][CS-1:0]     dqs_oe,
  input  logic [1:0]             cs_n,
  input  logic [1:0]             sel_eff,
  output logic                   p_sck,
  output logic                   p_sck_n,
  output logic [PW-1:0]          p_dout,
  output logic [PW-1:0]          p_doe,
  output logic [PS-1:0]          p_dqs_o,
  output logic [PS-1:0]          p_dqs_oe,
  output logic [1:0]             p_cs_n
);
  logic idx;
  logic live;

  assign idx  = (src == spr_pkg::SRC_B);
  assign live = (src != spr_pkg::SRC_NONE);

  always_comb begin
    p_sck    = 1'b0;
    p_sck_n  = 1'b0;
    p_dout   = '0;
    p_doe    = '0;
    p_dqs_o  = '0;
    p_dqs_oe = '0;
    if (live) begin
      p_sck    = sck[idx];
      p_sck_n  = sck_n[idx];
      p_dout   = dout[idx][PW-1:0];
      p_doe    = doe[idx][PW-1:0];
      p_dqs_o  = dqs_o[idx][PS-1:0];
      p_dqs_oe = dqs_oe[idx][PS-1:0];
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_cs
    assign p_cs_n[k] = (live && (sel_eff[idx] == 1'(k))) ? cs_n[idx] : 1'b1;
  end
endmodule

// File: rtl/spr_pin_router.sv
module spr_pin_router #(
  parameter int DW = 16,
  parameter int SW = 2,
  parameter int NW = 8,
  parameter int NS = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_share,
  input  logic          cfg_alt,
  input  logic          cfg_ovr_en,
  input  logic          cfg_ovr_sel_a,
  input  logic          cfg_ovr_sel_b,
  input  logic          owner,
  input  logic          a_en,
  input  logic          a_sck,
  input  logic          a_sck_n,
  input  logic [DW-1:0] a_dout,
  input  logic [DW-1:0] a_doe,
  output logic [DW-1:0] a_din,
  input  logic [SW-1:0] a_dqs_o,
  input  logic [SW-1:0] a_dqs_oe,
  output logic [SW-1:0] a_dqs_i,
  input  logic          a_cs_n,
  input  logic          a_cs_sel,
  input  logic          b_en,
  input  logic          b_sck,
  input  logic          b_sck_n,
  input  logic [DW-1:0] b_dout,
  input  logic [DW-1:0] b_doe,
  output logic [DW-1:0] b_din,
  input  logic [SW-1:0] b_dqs_o,
  input  logic [SW-1:0] b_dqs_oe,
  output logic [SW-1:0] b_dqs_i,
  input  logic          b_cs_n,
  input  logic          b_cs_sel,
  output logic          p1_sck,
  output logic          p1_sck_n,
  output logic [DW-1:0] p1_dout,
  output logic [DW-1:0] p1_doe,
  input  logic [DW-1:0] p1_din,
  output logic [SW-1:0] p1_dqs_o,
  output logic [SW-1:0] p1_dqs_oe,
  input  logic [SW-1:0] p1_dqs_i,
  output logic [1:0]    p1_cs_n,
  output logic          p2_sck,
  output logic          p2_sck_n,
  output logic [NW-1:0] p2_dout,
  output logic [NW-1:0] p2_doe,
  input  logic [NW-1:0] p2_din,
  output logic [NS-1:0] p2_dqs_o,
  output logic [NS-1:0] p2_dqs_oe,
  input  logic [NS-1:0] p2_dqs_i,
  output logic [1:0]    p2_cs_n
);
  import spr_pkg::*;

  logic share_q, alt_q, ovr_en_q, ovr_a_q, ovr_b_q;
  src_e src_p1, src_p2;

  logic [1:0]         sck_v, sck_n_v, cs_n_v, sel_eff;
  logic [1:0][DW-1:0] dout_v, doe_v;
  logic [1:0][SW-1:0] dqs_o_v, dqs_oe_v;
  logic [DW-1:0]      p2_din_x;
  logic [SW-1:0]      p2_dqs_x;
  logic [1:0][DW-1:0] din_back;
  logic [1:0][SW-1:0] dqs_back;

  spr_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .busy(a_en | b_en),
    .share_d(cfg_share), .alt_d(cfg_alt), .ovr_en_d(cfg_ovr_en),
    .ovr_a_d(cfg_ovr_sel_a), .ovr_b_d(cfg_ovr_sel_b),
    .share_q(share_q), .alt_q(alt_q), .ovr_en_q(ovr_en_q),
    .ovr_a_q(ovr_a_q), .ovr_b_q(ovr_b_q)
  );

  assign src_p1 = route_src(share_q, alt_q, owner, 1'b0);
  assign src_p2 = route_src(share_q, alt_q, owner, 1'b1);

  assign sck_v    = {b_sck, a_sck};
  assign sck_n_v  = {b_sck_n, a_sck_n};
  assign dout_v   = {b_dout, a_dout};
  assign doe_v    = {b_doe, a_doe};
  assign dqs_o_v  = {b_dqs_o, a_dqs_o};
  assign dqs_oe_v = {b_dqs_oe, a_dqs_oe};
  assign cs_n_v   = {b_cs_n, a_cs_n};
  assign sel_eff  = ovr_en_q ? {ovr_b_q, ovr_a_q} : {b_cs_sel, a_cs_sel};

  spr_port_mux #(.CW(DW), .CS(SW), .PW(DW), .PS(SW)) u_p1 (
    .src(src_p1), .sck(sck_v), .sck_n(sck_n_v), .dout(dout_v), .doe(doe_v),
    .dqs_o(dqs_o_v), .dqs_oe(dqs_oe_v), .cs_n(cs_n_v), .sel_eff(sel_eff),
    .p_sck(p1_sck), .p_sck_n(p1_sck_n), .p_dout(p1_dout), .p_doe(p1_doe),
    .p_dqs_o(p1_dqs_o), .p_dqs_oe(p1_dqs_oe), .p_cs_n(p1_cs_n)
  );

  spr_port_mux #(.CW(DW), .CS(SW), .PW(NW), .PS(NS)) u_p2 (
    .src(src_p2), .sck(sck_v), .sck_n(sck_n_v), .dout(dout_v), .doe(doe_v),
    .dqs_o(dqs_o_v), .dqs_oe(dqs_oe_v), .cs_n(cs_n_v), .sel_eff(sel_eff),
    .p_sck(p2_sck), .p_sck_n(p2_sck_n), .p_dout(p2_dout), .p_doe(p2_doe),
    .p_dqs_o(p2_dqs_o), .p_dqs_oe(p2_dqs_oe), .p_cs_n(p2_cs_n)
  );

  always_comb begin
    p2_din_x = '0;
    p2_din_x[NW-1:0] = p2_din;
    p2_dqs_x = '0;
    p2_dqs_x[NS-1:0] = p2_dqs_i;
  end

  for (genvar c = 0; c < 2; c++) begin : g_ret
    logic from_p1, from_p2;
    assign from_p1 = (src_p1 == src_e'(c));
    assign from_p2 = (src_p2 == src_e'(c));
    assign din_back[c] = (from_p1 ? p1_din : '0) | (from_p2 ? p2_din_x : '0);
    assign dqs_back[c] = (from_p1 ? p1_dqs_i : '0) | (from_p2 ? p2_dqs_x : '0);
  end

  assign a_din   = din_back[0];
  assign b_din   = din_back[1];
  assign a_dqs_i = dqs_back[0];
  assign b_dqs_i = dqs_back[1];
endmodule

// File: rtl/spr_router_chk.sv
module spr_router_chk #(
  parameter int DW = 16,
  parameter int NW = 8,
  parameter int NS = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_en,
  input logic          b_en,
  input logic          owner,
  input logic [4:0]    cfg_state,
  input logic [DW-1:0] a_dout,
  input logic [DW-1:0] b_dout,
  input logic [DW-1:0] a_din,
  input logic [DW-1:0] b_din,
  input logic [DW-1:0] p1_dout,
  input logic [DW-1:0] p1_doe,
  input logic [NW-1:0] p2_dout,
  input logic [NW-1:0] p2_doe,
  input logic [NS-1:0] p2_dqs_oe,
  input logic [1:0]    p1_cs_n,
  input logic [1:0]    p2_cs_n
);
  logic share, alt;
  assign share = cfg_state[4];
  assign alt   = cfg_state[3];

  // R8: configuration holds while a controller is enabled
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en || b_en) |=> $stable(cfg_state));

  // R6: at most one chip-select pin of a port is active
  a_r6_one_cs_p1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~p1_cs_n) <= 1);
  a_r6_one_cs_p2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~p2_cs_n) <= 1);

  // R4: port 2 idle while shared on port 1
  a_r4_p2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (share && !alt) |-> (p2_cs_n == 2'b11 && p2_doe == '0 && p2_dqs_oe == '0));

  // R5: port 1 idle while shared on port 2
  a_r5_p1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (share && alt) |-> (p1_cs_n == 2'b11 && p1_doe == '0));

  // R9: the non-owner reads zeros
  a_r9_nonowner_zero: assert property (@(posedge clk) disable iff (!rst_n)
    share |-> (owner ? (a_din == '0) : (b_din == '0)));

  // R2: straight mapping carries A to port 1 and B's low byte to port 2
  a_r2_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (!share && !alt) |-> (p1_dout == a_dout && p2_dout == b_dout[NW-1:0]));
endmodule

bind spr_pin_router spr_router_chk #(.DW(DW), .NW(NW), .NS(NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_en(a_en), .b_en(b_en), .owner(owner),
  .cfg_state({share_q, alt_q, ovr_en_q, ovr_a_q, ovr_b_q}),
  .a_dout(a_dout), .b_dout(b_dout), .a_din(a_din), .b_din(b_din),
  .p1_dout(p1_dout), .p1_doe(p1_doe), .p2_dout(p2_dout), .p2_doe(p2_doe),
  .p2_dqs_oe(p2_dqs_oe), .p1_cs_n(p1_cs_n), .p2_cs_n(p2_cs_n)
);

// File: tb/sim_spr_pin_router.sv
module sim_spr_pin_router;
  localparam int DW = 16, SW = 2, NW = 8, NS = 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic cfg_we, cfg_share, cfg_alt, cfg_ovr_en, cfg_ovr_sel_a, cfg_ovr_sel_b, owner;
  logic a_en, a_sck, a_sck_n, a_cs_n, a_cs_sel;
  logic b_en, b_sck, b_sck_n, b_cs_n, b_cs_sel;
  logic [DW-1:0] a_dout, a_doe, a_din, b_dout, b_doe, b_din;
  logic [SW-1:0] a_dqs_o, a_dqs_oe, a_dqs_i, b_dqs_o, b_dqs_oe, b_dqs_i;
  logic p1_sck, p1_sck_n, p2_sck, p2_sck_n;
  logic [DW-1:0] p1_dout, p1_doe, p1_din;
  logic [SW-1:0] p1_dqs_o, p1_dqs_oe, p1_dqs_i;
  logic [NW-1:0] p2_dout, p2_doe, p2_din;
  logic [NS-1:0] p2_dqs_o, p2_dqs_oe, p2_dqs_i;
  logic [1:0] p1_cs_n, p2_cs_n;

  spr_pin_router u0 (.*);

  // reference model state
  logic m_share, m_alt, m_ovr, m_oa, m_ob;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_share <= 0; m_alt <= 0; m_ovr <= 0; m_oa <= 0; m_ob <= 0;
    end else if (cfg_we && !a_en && !b_en) begin
      m_share <= cfg_share; m_alt <= cfg_alt; m_ovr <= cfg_ovr_en;
      m_oa <= cfg_ovr_sel_a; m_ob <= cfg_ovr_sel_b;
    end
  end

  int checks = 0, fails = 0;
  string tag = "R1";

  function automatic int who(int port);
    if (!m_share) return ((port == 1) == (m_alt == 0)) ? 0 : 1;
    if ((port == 2) == (m_alt == 1)) return owner ? 1 : 0;
    return -1;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] cs_exp(int s);
    logic sel, cs;
    if (s < 0) return 2'b11;
    sel = m_ovr ? (s == 0 ? m_oa : m_ob) : (s == 0 ? a_cs_sel : b_cs_sel);
    cs  = (s == 0) ? a_cs_n : b_cs_n;
    return sel ? {cs, 1'b1} : {1'b1, cs};
  endfunction

  task automatic compare();
    int s1 = who(1), s2 = who(2);
    string cst = m_ovr ? "R7" : (m_share ? "R11" : "R6");
    logic [DW-1:0] ea, eb;
    logic [SW-1:0] qa, qb;
    chk(tag, "p1_sck", 32'(p1_sck), s1 < 0 ? 0 : 32'(s1 == 0 ? a_sck : b_sck));
    chk(tag, "p1_sck_n", 32'(p1_sck_n), s1 < 0 ? 0 : 32'(s1 == 0 ? a_sck_n : b_sck_n));
    chk(tag, "p1_dout", 32'(p1_dout), s1 < 0 ? 0 : 32'(s1 == 0 ? a_dout : b_dout));
    chk(tag, "p1_doe", 32'(p1_doe), s1 < 0 ? 0 : 32'(s1 == 0 ? a_doe : b_doe));
    chk(tag, "p1_dqs_o", 32'(p1_dqs_o), s1 < 0 ? 0 : 32'(s1 == 0 ? a_dqs_o : b_dqs_o));
    chk(tag, "p1_dqs_oe", 32'(p1_dqs_oe), s1 < 0 ? 0 : 32'(s1 == 0 ? a_dqs_oe : b_dqs_oe));
    chk(tag, "p2_sck", 32'(p2_sck), s2 < 0 ? 0 : 32'(s2 == 0 ? a_sck : b_sck));
    chk(tag, "p2_sck_n", 32'(p2_sck_n), s2 < 0 ? 0 : 32'(s2 == 0 ? a_sck_n : b_sck_n));
    chk("R10", "p2_dout", 32'(p2_dout), s2 < 0 ? 0 : 32'((s2 == 0 ? a_dout : b_dout) & 16'h00ff));
    chk("R10", "p2_doe", 32'(p2_doe), s2 < 0 ? 0 : 32'((s2 == 0 ? a_doe : b_doe) & 16'h00ff));
    chk("R10", "p2_dqs_o", 32'(p2_dqs_o), s2 < 0 ? 0 : 32'((s2 == 0 ? a_dqs_o : b_dqs_o) & 2'b01));
    chk("R10", "p2_dqs_oe", 32'(p2_dqs_oe), s2 < 0 ? 0 : 32'((s2 == 0 ? a_dqs_oe : b_dqs_oe) & 2'b01));
    chk(cst, "p1_cs_n", 32'(p1_cs_n), 32'(cs_exp(s1)));
    chk(cst, "p2_cs_n", 32'(p2_cs_n), 32'(cs_exp(s2)));
    ea = '0; eb = '0; qa = '0; qb = '0;
    if (s1 == 0) begin ea = ea | p1_din; qa = qa | p1_dqs_i; end
    if (s1 == 1) begin eb = eb | p1_din; qb = qb | p1_dqs_i; end
    if (s2 == 0) begin ea = ea | {8'h00, p2_din}; qa = qa | {1'b0, p2_dqs_i}; end
    if (s2 == 1) begin eb = eb | {8'h00, p2_din}; qb = qb | {1'b0, p2_dqs_i}; end
    chk("R9", "a_din", 32'(a_din), 32'(ea));
    chk("R9", "b_din", 32'(b_din), 32'(eb));
    chk("R9", "a_dqs_i", 32'(a_dqs_i), 32'(qa));
    chk("R9", "b_dqs_i", 32'(b_dqs_i), 32'(qb));
  endtask

  task automatic scramble(logic en_rand);
    a_sck = 1'($urandom); a_sck_n = ~a_sck; b_sck = 1'($urandom); b_sck_n = ~b_sck;
    a_dout = 16'($urandom); a_doe = 16'($urandom); b_dout = 16'($urandom); b_doe = 16'($urandom);
    a_dqs_o = 2'($urandom); a_dqs_oe = 2'($urandom); b_dqs_o = 2'($urandom); b_dqs_oe = 2'($urandom);
    a_cs_n = 1'($urandom); b_cs_n = 1'($urandom); a_cs_sel = 1'($urandom); b_cs_sel = 1'($urandom);
    p1_din = 16'($urandom); p1_dqs_i = 2'($urandom); p2_din = 8'($urandom); p2_dqs_i = 1'($urandom);
    owner = 1'($urandom);
    if (en_rand) begin a_en = 1'($urandom); b_en = 1'($urandom); end
  endtask

  task automatic run(int n, logic en_rand);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      scramble(en_rand);
    end
  endtask

  function automatic string mode_tag(logic sh, logic al);
    if (!sh) return al ? "R3" : "R2";
    return al ? "R5" : "R4";
  endfunction

  task automatic write_cfg(logic sh, logic al, logic ov, logic oa, logic ob);
    @(negedge clk);
    a_en = 0; b_en = 0; cfg_we = 1;
    cfg_share = sh; cfg_alt = al; cfg_ovr_en = ov; cfg_ovr_sel_a = oa; cfg_ovr_sel_b = ob;
    @(negedge clk);
    cfg_we = 0;
    tag = mode_tag(sh, al);
  endtask

  bit done = 0;
  initial begin
    #500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_share = 1; cfg_alt = 1; cfg_ovr_en = 1;
    cfg_ovr_sel_a = 1; cfg_ovr_sel_b = 1; a_en = 0; b_en = 0;
    scramble(1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    run(10, 1'b0);
    for (int m = 0; m < 8; m++) begin
      write_cfg(m[0], m[1], m[2], m[0] ^ m[1], m[1]);
      run(150, 1'b1);
    end
    write_cfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    tag = "R8";
    @(negedge clk);
    a_en = 1; cfg_we = 1; cfg_share = 1; cfg_alt = 0; cfg_ovr_en = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      compare();
      scramble(1'b0);
      a_en = (i % 2 == 0); b_en = ~a_en;
    end
    cfg_we = 0; a_en = 0; b_en = 0;
    run(5, 1'b0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule